// File: doc/BRIEF.md
# PLL Feedback-Divider Slide Sequencer

This block moves the feedback multiplier N of a PLL that is already running to a new value without letting the loop lose lock. It uses the PLL's built-in dynamic ramp rather than reprogramming the PLL from bypass. A single-cycle pulse on the request input carries the new N. The sequencer then acts as a master on a simple register port and works through the PLL configuration registers in a fixed order.

The first access reads the coefficient register. If its N field already holds the requested value, the block finishes at once. Otherwise it loads the two ramp step constants and enters slowdown mode. It then writes the new N and arms the ramp. Next it polls the synced ramp-done flag. Polls are spaced a programmable number of clocks apart, and their number is capped. Finally it leaves slowdown and ramp mode in one write and reads that register back.

A done pulse marks the end of a request. A timeout flag accompanies the done pulse when the ramp never reported completion. Every field update is a read followed by a write of the same register, and all bits outside the field are kept. Requests that arrive while a sequence is running are dropped.

Top module: `ndiv_slide_seq`

## Requirements
- R1: A request accepted while idle (busy low) raises busy and puts a read of the coefficient register on the bus in the cycle that follows the accepting clock edge.
- R2: If bits 15:8 of that coefficient read equal the requested N, the next cycle is the done cycle with timeout low, and no register is written.
- R3: Otherwise configuration register 2 is rewritten with 0x2b in bits 31:24, then configuration register 3 with 0x0b in bits 23:16, with every other bit kept as read.
- R4: Next, bit 22 (slowdown via PLL) of the slowdown register is set, with all other bits kept.
- R5: Then only bits 15:8 of the coefficient register are replaced by the new N, and after that bit 31 (ramp enable) of the slowdown register is set.
- R6: Each write goes to the address read in the cycle just before it and carries the read value modified only in its field; bus accesses run back to back, one per cycle.
- R7: Before every read of the debug status register the bus is idle for exactly POLL_GAP cycles, and polling stops at the first read with bit 24 set.
- R8: At most MAX_POLLS debug reads are made. If none shows bit 24, timeout is high in the done cycle.
- R9: After polling, whether it succeeded or timed out, the slowdown register is read, written back with bits 22 and 31 both cleared and other bits kept, and read once more. The done cycle follows that final read.
- R10: A request pulse that arrives while busy is high has no effect on the bus sequence, and it does not start another sequence afterwards.
- R11: Done is high for exactly one cycle, with busy high and the bus idle. Busy is low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle request strobe |
| reqN | input | 8 | Requested feedback multiplier |
| busEn | output | 1 | Register access this cycle |
| busWe | output | 1 | Access is a write |
| busAddr | output | ADDR_W | Register address |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, returned in the same cycle as the access |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Ramp never completed; valid with done |

## Verification
The first bus access is due one cycle after the edge that takes the request. After that the accesses follow one per cycle, apart from the POLL_GAP idle cycles before each poll. Done comes one cycle after the coefficient read when N is unchanged, and one cycle after the final slowdown read back otherwise. The bench builds the whole expected per-cycle stream for each request in advance. This stream covers bus strobes, address, write data, busy, done and timeout. The bench starts it with one idle entry, so that it lines up with the request edge, and compares one entry at every falling edge. A register-file model answers the reads and reports ramp-done only after a chosen number of polls. This lets the single-poll, 500th-poll and timeout cases fall on known cycles.

// File: rtl/slide_pkg.sv
package slide_pkg;
  localparam int DATA_W    = 32;
  localparam int NDIV_W    = 8;
  localparam int NDIV_LSB  = 8;
  localparam int STEP_W    = 8;
  localparam int STEPA_LSB = 24;
  localparam int STEPB_LSB = 16;
  localparam int SLOW_BIT  = 22;
  localparam int RAMP_BIT  = 31;
  localparam int DONE_BIT  = 24;

  typedef enum logic [2:0] {
    SEL_COEF, SEL_CFG2, SEL_CFG3, SEL_SLOW, SEL_DBG
  } regSel_e;

  typedef enum logic [2:0] {
    OP_STEPA, OP_STEPB, OP_SLOWSET, OP_NSET, OP_RAMPSET, OP_EXIT
  } modOp_e;

  typedef enum logic [4:0] {
    ST_IDLE, ST_CHK, ST_RDA, ST_WRA, ST_RDB, ST_WRB, ST_RDS0, ST_WRS0,
    ST_RDN, ST_WRN, ST_RDS1, ST_WRS1, ST_GAP, ST_POLL, ST_RDX, ST_WRX,
    ST_RB, ST_FIN
  } seqState_e;

  typedef struct packed {
    logic    rd;
    logic    wr;
    regSel_e sel;
    modOp_e  op;
    logic    loadTarget;
    logic    gapLoad;
    logic    gapDec;
    logic    pollInc;
    logic    errSet;
  } dpCtl_t;
endpackage

// File: rtl/slide_dp.sv
module slide_dp
  import slide_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_COEF = 12'h004,
  parameter logic [ADDR_W-1:0] ADDR_CFG2 = 12'h00C,
  parameter logic [ADDR_W-1:0] ADDR_CFG3 = 12'h018,
  parameter logic [ADDR_W-1:0] ADDR_SLOW = 12'h01C,
  parameter logic [ADDR_W-1:0] ADDR_DBG  = 12'h0A0,
  parameter int MAX_POLLS = 500,
  parameter int POLL_GAP  = 50,
  parameter logic [STEP_W-1:0] STEP_A = 8'h2b,
  parameter logic [STEP_W-1:0] STEP_B = 8'h0b
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [NDIV_W-1:0] reqN,
  input  logic [DATA_W-1:0] busRdata,
  output logic              busEn,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              nMatch,
  output logic              doneBit,
  output logic              pollLast,
  output logic              gapZero,
  output logic              errFlag
);
  localparam int POLL_CW = $clog2(MAX_POLLS + 1);
  localparam int GAP_CW  = $clog2(POLL_GAP + 1);

  logic [NDIV_W-1:0]  targetN;
  logic [DATA_W-1:0]  capData;
  logic [POLL_CW-1:0] pollCnt;
  logic [GAP_CW-1:0]  gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetN <= '0;
      capData <= '0;
      pollCnt <= '0;
      gapCnt  <= '0;
      errFlag <= 1'b0;
    end else begin
      if (ctl.loadTarget) begin
        targetN <= reqN;
        pollCnt <= '0;
        errFlag <= 1'b0;
      end
      if (ctl.rd) capData <= busRdata;
      if (ctl.gapLoad) gapCnt <= GAP_CW'(POLL_GAP - 1);
      else if (ctl.gapDec) gapCnt <= gapCnt - 1'b1;
      if (ctl.pollInc) pollCnt <= pollCnt + 1'b1;
      if (ctl.errSet) errFlag <= 1'b1;
    end
  end

  assign nMatch   = (busRdata[NDIV_LSB +: NDIV_W] == targetN);
  assign doneBit  = busRdata[DONE_BIT];
  assign pollLast = (pollCnt == POLL_CW'(MAX_POLLS - 1));
  assign gapZero  = (gapCnt == '0);
  assign busEn    = ctl.rd | ctl.wr;
  assign busWe    = ctl.wr;

  always_comb begin
    case (ctl.sel)
      SEL_COEF: busAddr = ADDR_COEF;
      SEL_CFG2: busAddr = ADDR_CFG2;
      SEL_CFG3: busAddr = ADDR_CFG3;
      SEL_SLOW: busAddr = ADDR_SLOW;
      default:  busAddr = ADDR_DBG;
    endcase
  end

  always_comb begin
    busWdata = capData;
    case (ctl.op)
      OP_STEPA:   busWdata[STEPA_LSB +: STEP_W] = STEP_A;
      OP_STEPB:   busWdata[STEPB_LSB +: STEP_W] = STEP_B;
      OP_SLOWSET: busWdata[SLOW_BIT] = 1'b1;
      OP_NSET:    busWdata[NDIV_LSB +: NDIV_W] = targetN;
      OP_RAMPSET: busWdata[RAMP_BIT] = 1'b1;
      default: begin
        busWdata[SLOW_BIT] = 1'b0;
        busWdata[RAMP_BIT] = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/slide_ctrl.sv
module slide_ctrl
  import slide_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   nMatch,
  input  logic   doneBit,
  input  logic   pollLast,
  input  logic   gapZero,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done
);
  seqState_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      ST_IDLE: if (reqValid) begin ctl.loadTarget = 1'b1; nxt = ST_CHK; end
      ST_CHK: begin
        ctl.rd = 1'b1; ctl.sel = SEL_COEF;
        nxt = nMatch ? ST_FIN : ST_RDA;
      end
      ST_RDA:  begin ctl.rd = 1'b1; ctl.sel = SEL_CFG2; nxt = ST_WRA; end
      ST_WRA:  begin ctl.wr = 1'b1; ctl.sel = SEL_CFG2; ctl.op = OP_STEPA; nxt = ST_RDB; end
      ST_RDB:  begin ctl.rd = 1'b1; ctl.sel = SEL_CFG3; nxt = ST_WRB; end
      ST_WRB:  begin ctl.wr = 1'b1; ctl.sel = SEL_CFG3; ctl.op = OP_STEPB; nxt = ST_RDS0; end
      ST_RDS0: begin ctl.rd = 1'b1; ctl.sel = SEL_SLOW; nxt = ST_WRS0; end
      ST_WRS0: begin ctl.wr = 1'b1; ctl.sel = SEL_SLOW; ctl.op = OP_SLOWSET; nxt = ST_RDN; end
      ST_RDN:  begin ctl.rd = 1'b1; ctl.sel = SEL_COEF; nxt = ST_WRN; end
      ST_WRN:  begin ctl.wr = 1'b1; ctl.sel = SEL_COEF; ctl.op = OP_NSET; nxt = ST_RDS1; end
      ST_RDS1: begin ctl.rd = 1'b1; ctl.sel = SEL_SLOW; nxt = ST_WRS1; end
      ST_WRS1: begin
        ctl.wr = 1'b1; ctl.sel = SEL_SLOW; ctl.op = OP_RAMPSET;
        ctl.gapLoad = 1'b1; nxt = ST_GAP;
      end
      ST_GAP: begin
        if (gapZero) nxt = ST_POLL;
        else ctl.gapDec = 1'b1;
      end
      ST_POLL: begin
        ctl.rd = 1'b1; ctl.sel = SEL_DBG;
        if (doneBit) nxt = ST_RDX;
        else if (pollLast) begin ctl.errSet = 1'b1; nxt = ST_RDX; end
        else begin ctl.pollInc = 1'b1; ctl.gapLoad = 1'b1; nxt = ST_GAP; end
      end
      ST_RDX:  begin ctl.rd = 1'b1; ctl.sel = SEL_SLOW; nxt = ST_WRX; end
      ST_WRX:  begin ctl.wr = 1'b1; ctl.sel = SEL_SLOW; ctl.op = OP_EXIT; nxt = ST_RB; end
      ST_RB:   begin ctl.rd = 1'b1; ctl.sel = SEL_SLOW; nxt = ST_FIN; end
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/ndiv_slide_seq.sv
module ndiv_slide_seq
  import slide_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_COEF = 12'h004,
  parameter logic [ADDR_W-1:0] ADDR_CFG2 = 12'h00C,
  parameter logic [ADDR_W-1:0] ADDR_CFG3 = 12'h018,
  parameter logic [ADDR_W-1:0] ADDR_SLOW = 12'h01C,
  parameter logic [ADDR_W-1:0] ADDR_DBG  = 12'h0A0,
  parameter int MAX_POLLS = 500,
  parameter int POLL_GAP  = 50,
  parameter logic [7:0] STEP_A = 8'h2b,
  parameter logic [7:0] STEP_B = 8'h0b
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [7:0]        reqN,
  output logic              busEn,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  input  logic [31:0]       busRdata,
  output logic              busy,
  output logic              done,
  output logic              timeout
);
  dpCtl_t ctl;
  logic nMatch, doneBit, pollLast, gapZero, errFlag;

  slide_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .nMatch(nMatch),
    .doneBit(doneBit), .pollLast(pollLast), .gapZero(gapZero),
    .ctl(ctl), .busy(busy), .done(done)
  );

  slide_dp #(
    .ADDR_W(ADDR_W), .ADDR_COEF(ADDR_COEF), .ADDR_CFG2(ADDR_CFG2),
    .ADDR_CFG3(ADDR_CFG3), .ADDR_SLOW(ADDR_SLOW), .ADDR_DBG(ADDR_DBG),
    .MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP), .STEP_A(STEP_A), .STEP_B(STEP_B)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqN(reqN), .busRdata(busRdata),
    .busEn(busEn), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .nMatch(nMatch), .doneBit(doneBit), .pollLast(pollLast),
    .gapZero(gapZero), .errFlag(errFlag)
  );

  assign timeout = done & errFlag;
endmodule

// File: rtl/slide_chk.sv
module slide_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_COEF = 12'h004,
  parameter logic [ADDR_W-1:0] ADDR_CFG2 = 12'h00C,
  parameter logic [7:0] STEP_A = 8'h2b
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busEn,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              busy,
  input logic              done,
  input logic              timeout
);
  // R1
  req_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> (busy && busEn && !busWe && busAddr == ADDR_COEF));
  // R6
  rmw_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && busWe) |-> ($past(busEn) && !$past(busWe) && $past(busAddr) == busAddr));
  // R3
  step_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && busWe && busAddr == ADDR_CFG2) |->
      (busWdata[31:24] == STEP_A && busWdata[23:0] == $past(busRdata[23:0])));
  // R8
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> done);
  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && !busEn));
  // R11
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busEn);
endmodule

bind ndiv_slide_seq slide_chk #(
  .ADDR_W(ADDR_W), .ADDR_COEF(ADDR_COEF), .ADDR_CFG2(ADDR_CFG2), .STEP_A(STEP_A)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busEn(busEn), .busWe(busWe),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busy(busy),
  .done(done), .timeout(timeout)
);

// File: tb/ndiv_slide_seq_bench.sv
module ndiv_slide_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP  = 3;
  localparam int MAXP = 500;
  localparam logic [11:0] A_COEF = 12'h004, A_CFG2 = 12'h00C, A_CFG3 = 12'h018,
                          A_SLOW = 12'h01C, A_DBG = 12'h0A0;

  logic clk = 1'b0, rstN = 1'b0, reqValid = 1'b0;
  logic [7:0] reqN = '0;
  logic busEn, busWe, busy, done, timeout;
  logic [11:0] busAddr;
  logic [31:0] busWdata, busRdata;

  int checks = 0, failures = 0;
  bit chkOn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ndiv_slide_seq #(.POLL_GAP(GAP), .MAX_POLLS(MAXP)) u_ndiv_slide_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqN(reqN),
    .busEn(busEn), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busy(busy), .done(done), .timeout(timeout)
  );

  // register-file model of the PLL side
  logic [31:0] rCoef = 32'h0A3F4005, rCfg2 = 32'h5500AA33, rCfg3 = 32'h77CC1199,
               rSlow = 32'h00A0005C, rDbg = 32'h02000011;
  int dbgReads = 0, doneAfter = 0;

  always_comb begin
    case (busAddr)
      A_COEF:  busRdata = rCoef;
      A_CFG2:  busRdata = rCfg2;
      A_CFG3:  busRdata = rCfg3;
      A_SLOW:  busRdata = rSlow;
      A_DBG:   busRdata = (dbgReads >= doneAfter) ? (rDbg | 32'h01000000) : rDbg;
      default: busRdata = 32'h0;
    endcase
  end

  always @(posedge clk) begin
    if (rstN && busEn) begin
      if (busWe) begin
        case (busAddr)
          A_COEF: rCoef <= busWdata;
          A_CFG2: rCfg2 <= busWdata;
          A_CFG3: rCfg3 <= busWdata;
          A_SLOW: rSlow <= busWdata;
          default: ;
        endcase
      end else if (busAddr == A_DBG) dbgReads <= dbgReads + 1;
    end
  end

  // expected per-cycle stream: kind 0 idle, 1 read, 2 write, 3 done cycle
  typedef struct {
    int kind; logic [11:0] addr; logic [31:0] data; bit bsy; bit tout; string req;
  } ent_t;
  ent_t expQ[$];
  logic [31:0] mCoef = 32'h0A3F4005, mCfg2 = 32'h5500AA33, mCfg3 = 32'h77CC1199,
               mSlow = 32'h00A0005C;

  task automatic push(int k, logic [11:0] a, logic [31:0] d, bit b, bit t, string r);
    ent_t e;
    e.kind = k; e.addr = a; e.data = d; e.bsy = b; e.tout = t; e.req = r;
    expQ.push_back(e);
  endtask

  task automatic genSeq(logic [7:0] n, int k);
    int np;
    push(0, 0, 0, 0, 0, "R1");
    push(1, A_COEF, 0, 1, 0, "R1");
    if (mCoef[15:8] == n) begin
      push(3, 0, 0, 1, 0, "R2");        // R2: no writes, done next
    end else begin
      push(1, A_CFG2, 0, 1, 0, "R6");
      mCfg2[31:24] = 8'h2b;
      push(2, A_CFG2, mCfg2, 1, 0, "R3");
      push(1, A_CFG3, 0, 1, 0, "R6");
      mCfg3[23:16] = 8'h0b;
      push(2, A_CFG3, mCfg3, 1, 0, "R3");
      push(1, A_SLOW, 0, 1, 0, "R6");
      mSlow[22] = 1'b1;
      push(2, A_SLOW, mSlow, 1, 0, "R4");
      push(1, A_COEF, 0, 1, 0, "R6");
      mCoef[15:8] = n;
      push(2, A_COEF, mCoef, 1, 0, "R5");
      push(1, A_SLOW, 0, 1, 0, "R6");
      mSlow[31] = 1'b1;
      push(2, A_SLOW, mSlow, 1, 0, "R5");
      np = (k < MAXP) ? k + 1 : MAXP;
      for (int p = 0; p < np; p++) begin
        for (int g = 0; g < GAP; g++) push(0, 0, 0, 1, 0, "R7");
        push(1, A_DBG, 0, 1, 0, (p == MAXP - 1) ? "R8" : "R7");
      end
      push(1, A_SLOW, 0, 1, 0, "R9");
      mSlow[22] = 1'b0; mSlow[31] = 1'b0;
      push(2, A_SLOW, mSlow, 1, 0, "R9");
      push(1, A_SLOW, 0, 1, 0, "R9");
      push(3, 0, 0, 1, (k >= MAXP), "R8");
    end
    for (int i = 0; i < 3; i++) push(0, 0, 0, 0, 0, "R11");
  endtask

  // compared on every falling edge
  always @(negedge clk) begin
    if (chkOn) begin
      ent_t e;
      bit ok;
      if (expQ.size() > 0) e = expQ.pop_front();
      else begin e.kind = 0; e.addr = 0; e.data = 0; e.bsy = 0; e.tout = 0; e.req = "R10"; end
      ok = (busy === e.bsy) && (done === (e.kind == 3)) &&
           (timeout === (e.kind == 3 && e.tout)) &&
           (busEn === (e.kind == 1 || e.kind == 2));
      if (e.kind == 1 || e.kind == 2)
        ok = ok && (busWe === (e.kind == 2)) && (busAddr === e.addr);
      if (e.kind == 2) ok = ok && (busWdata === e.data);
      checks++;
      if (!ok) begin
        failures++;
        $display("FAIL %s t=%0t act busy=%b done=%b to=%b en=%b we=%b a=%h d=%h exp kind=%0d busy=%b to=%b a=%h d=%h",
                 e.req, $time, busy, done, timeout, busEn, busWe, busAddr, busWdata,
                 e.kind, e.bsy, e.tout, e.addr, e.data);
      end
    end
  end

  task automatic runReq(logic [7:0] n, int k, bit intrude);
    @(posedge clk); #1;
    doneAfter = k; dbgReads = 0;
    genSeq(n, k);
    reqValid = 1'b1; reqN = n;
    @(posedge clk); #1 reqValid = 1'b0;
    if (intrude) begin   // R10: request while busy must be dropped
      repeat (4) @(posedge clk);
      #1 reqValid = 1'b1; reqN = ~n;
      @(posedge clk); #1 reqValid = 1'b0;
    end
    wait (expQ.size() == 0);
    @(posedge clk);
    checks++;              // R5: register contents after the sequence
    if (rCoef !== mCoef || rCfg2 !== mCfg2 || rCfg3 !== mCfg3 || rSlow !== mSlow) begin
      failures++;
      $display("FAIL R5 regs act=%h %h %h %h exp=%h %h %h %h",
               rCoef, rCfg2, rCfg3, rSlow, mCoef, mCfg2, mCfg3, mSlow);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;              // R1: reset state
    if (busy !== 1'b0 || done !== 1'b0 || busEn !== 1'b0 || timeout !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset act busy=%b done=%b en=%b to=%b exp 0 0 0 0",
               busy, done, busEn, timeout);
    end
    @(posedge clk); #1 rstN = 1'b1; chkOn = 1;
    runReq(8'h40, 0, 0);   // R2 unchanged N
    runReq(8'h50, 0, 0);   // done on first poll
    runReq(8'h30, 7, 1);   // R10 with intruding request
    runReq(8'h31, 499, 0); // R8 done on last allowed poll
    runReq(8'h32, 500, 0); // R8 timeout
    runReq(8'h32, 0, 0);   // R2 after timeout, N already written
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule